// File: doc/BRIEF.md
# Edge-Triggered DMA Request Channel

This block captures external transfer requests for one DMA channel whose request pin is active low and edge-triggered. It also runs a minimal single-address transfer sequencer for that channel. The request pin is sampled on every rising clock edge, but only while the channel is enabled and armed. A low level seen while armed turns into a held request. When the channel starts servicing that request, the held request is cleared and the block stops accepting new ones. The channel re-arms only once two things are true: the pin has been seen high again, and the serviced cycle, including its write phase, has finished. A pin held low across several transfers therefore yields exactly one request. A fresh high-to-low transition is needed for the next one.

Software-side control is a write strobe carrying the enable bit and a transfer count. Each serviced request goes through three steps. First the channel waits at least a minimum number of cycles for the bus to be released, and until a bus-grant input is high. Then it runs a fixed-length read phase followed by a write phase. Throughout that cycle it drives the acknowledge and busy outputs. When the count runs out, the channel clears its own enable, pulses a done flag and stops sampling the pin.

Top module: `dreq_edge_channel`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, the outputs `req_pending`, `dack`, `cycle_busy` and `xfer_done` are all 0, and the channel is disabled.
- R2: While the channel is disabled, `dreq_n` is ignored. After an enabling write (`en_wr`=1, `en_wdata`=1, nonzero `xfer_count`), the first clock edge that samples `dreq_n` is the one following the write edge. The write edge itself samples nothing.
- R3: When the channel is armed and a clock edge samples `dreq_n`=0, `req_pending` is 1 in the following cycle. The next edge starts servicing the request and clears `req_pending`, so a held request shows for exactly one cycle.
- R4: After activation, the sequencer waits at least WAIT_MIN cycles. It then needs `bus_grant`=1 before starting the single cycle. With the grant already high, `cycle_busy` rises WAIT_MIN+1 cycles after `req_pending` rises. With the grant withheld, it rises on the first edge after the grant is given.
- R5: A single cycle lasts RD_CYC read cycles plus WR_CYC write cycles. `cycle_busy` and `dack` are both 1 for exactly RD_CYC+WR_CYC consecutive cycles and 0 otherwise.
- R6: No new request is held between activation and the re-arm point. The channel re-arms at the end of the single cycle if `dreq_n` was sampled high at any edge since activation. Otherwise it re-arms at the first later edge that samples `dreq_n` high, and only a subsequent low sample latches a new request.
- R7: Each completed single cycle decrements the transfer count. On the cycle that ends the transfer the count reaches zero, and that cycle has three effects:
  - `xfer_done` is 1 for exactly one cycle, the same cycle in which `dack` falls.
  - The enable is cleared.
  - Later `dreq_n` lows produce no request.
- R8: An enabling write with `xfer_count`=0 leaves the channel disabled. A write with `en_wdata`=0 disables the channel and drops any armed or held request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | One-cycle strobe writing the enable bit and transfer count |
| en_wdata | input | 1 | Enable bit value written by `en_wr` |
| xfer_count | input | CNT_W | Number of single transfers, loaded by an enabling write |
| dreq_n | input | 1 | Transfer request pin, active low, already synchronous to `clk` |
| bus_grant | input | 1 | High when the bus has been released to this channel |
| req_pending | output | 1 | A request has been latched and awaits activation |
| dack | output | 1 | Device acknowledge, high during the single cycle |
| cycle_busy | output | 1 | Single transfer cycle (read and write phase) in progress |
| xfer_done | output | 1 | One-cycle pulse when the last transfer completes |

## Verification
The properties assume that `dreq_n` and `bus_grant` are already synchronous to the clock. They also assume that enable writes happen only while no single cycle is in flight. The latency and length checks rely on this, because a disable in the middle of a cycle is not part of the measured sequences. The stimulus changes every input on the falling clock edge and issues control writes only after `dack` has fallen. It withholds the grant for one long stretch to exercise the waiting path, while the grant otherwise stays high. Assertions that tie a rising `cycle_busy` to the grant and to the wait count therefore hold under both grant behaviours.

// File: rtl/dreq_chan_pkg.sv
package dreq_chan_pkg;

    typedef enum logic [1:0] {
        DET_OFF   = 2'd0,
        DET_ARMED = 2'd1,
        DET_HELD  = 2'd2,
        DET_WATCH = 2'd3
    } det_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_READ  = 2'd2,
        SEQ_WRITE = 2'd3
    } seq_state_e;

    typedef struct packed {
        det_state_e st;
        logic       seen_high;
    } det_regs_t;

endpackage

// File: rtl/dreq_detect.sv
module dreq_detect
    import dreq_chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_start,
    input  logic arm_stop,
    input  logic dreq_n,
    input  logic seq_idle,
    input  logic cycle_end,
    output logic pending
);

    det_regs_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        unique case (det_q.st)
            DET_OFF: begin
                if (arm_start) begin
                    det_d.st        = DET_ARMED;
                    det_d.seen_high = 1'b0;
                end
            end
            DET_ARMED: begin
                if (!dreq_n) begin
                    det_d.st = DET_HELD;
                end
            end
            DET_HELD: begin
                // activation: the sequencer takes the request on this edge
                if (seq_idle) begin
                    det_d.st        = DET_WATCH;
                    det_d.seen_high = 1'b0;
                end
            end
            DET_WATCH: begin
                if (dreq_n) begin
                    det_d.seen_high = 1'b1;
                end
                if ((det_q.seen_high || dreq_n) && (cycle_end || seq_idle)) begin
                    det_d.st        = DET_ARMED;
                    det_d.seen_high = 1'b0;
                end
            end
            default: det_d.st = DET_OFF;
        endcase
        if (arm_stop) begin
            det_d.st        = DET_OFF;
            det_d.seen_high = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q <= '{st: DET_OFF, seen_high: 1'b0};
        end else begin
            det_q <= det_d;
        end
    end

    assign pending = (det_q.st == DET_HELD);

endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             cycle_end,
    output logic             chan_en,
    output logic             arm_start,
    output logic             arm_stop,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t cnt_d, cnt_q;
    logic      finish;
    logic      sw_off;

    always_comb begin
        arm_start = en_wr && en_wdata && (xfer_count != '0) && !cnt_q.en;
        sw_off    = en_wr && !en_wdata;
        finish    = cycle_end && cnt_q.en && (cnt_q.cnt == ONE);
        arm_stop  = (sw_off && cnt_q.en) || finish;

        cnt_d      = cnt_q;
        cnt_d.done = finish;
        if (arm_start) begin
            cnt_d.en  = 1'b1;
            cnt_d.cnt = xfer_count;
        end else if (sw_off) begin
            cnt_d.en  = 1'b0;
            cnt_d.cnt = '0;
        end else if (cycle_end && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - ONE;
            if (finish) begin
                cnt_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign chan_en = cnt_q.en;
    assign done    = cnt_q.done;

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import dreq_chan_pkg::*;
#(
    parameter int WAIT_MIN = 3,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic chan_en,
    input  logic bus_grant,
    output logic seq_idle,
    output logic cycle_end,
    output logic busy,
    output logic dack
);

    localparam int PH_MAX = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int WW     = $clog2(WAIT_MIN + 1);
    localparam int PW     = $clog2(PH_MAX + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_MIN - 1);
    localparam logic [PW-1:0] RD_LAST   = PW'(RD_CYC - 1);
    localparam logic [PW-1:0] WR_LAST   = PW'(WR_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [WW-1:0] wcnt;
        logic [PW-1:0] pcnt;
        logic          busy;
        logic          dack;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_idle  = (seq_q.st == SEQ_IDLE);
        cycle_end = (seq_q.st == SEQ_WRITE) && (seq_q.pcnt == WR_LAST);

        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (pending && chan_en) begin
                    seq_d.st   = SEQ_WAIT;
                    seq_d.wcnt = '0;
                end
            end
            SEQ_WAIT: begin
                if ((seq_q.wcnt >= WAIT_LAST) && bus_grant) begin
                    seq_d.st   = SEQ_READ;
                    seq_d.pcnt = '0;
                end else if (seq_q.wcnt < WAIT_LAST) begin
                    seq_d.wcnt = seq_q.wcnt + 1'b1;
                end
            end
            SEQ_READ: begin
                if (seq_q.pcnt == RD_LAST) begin
                    seq_d.st   = SEQ_WRITE;
                    seq_d.pcnt = '0;
                end else begin
                    seq_d.pcnt = seq_q.pcnt + 1'b1;
                end
            end
            SEQ_WRITE: begin
                if (cycle_end) begin
                    seq_d.st   = SEQ_IDLE;
                    seq_d.pcnt = '0;
                end else begin
                    seq_d.pcnt = seq_q.pcnt + 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
        seq_d.busy = (seq_d.st == SEQ_READ) || (seq_d.st == SEQ_WRITE);
        seq_d.dack = seq_d.busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: SEQ_IDLE, wcnt: '0, pcnt: '0, busy: 1'b0, dack: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = seq_q.busy;
    assign dack = seq_q.dack;

endmodule

// File: rtl/dreq_edge_channel.sv
module dreq_edge_channel #(
    parameter int CNT_W    = 8,
    parameter int WAIT_MIN = 3,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             dreq_n,
    input  logic             bus_grant,
    output logic             req_pending,
    output logic             dack,
    output logic             cycle_busy,
    output logic             xfer_done
);

    logic chan_en;
    logic arm_start;
    logic arm_stop;
    logic seq_idle;
    logic cycle_end;

    xfer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .xfer_count (xfer_count),
        .cycle_end  (cycle_end),
        .chan_en    (chan_en),
        .arm_start  (arm_start),
        .arm_stop   (arm_stop),
        .done       (xfer_done)
    );

    dreq_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .arm_start (arm_start),
        .arm_stop  (arm_stop),
        .dreq_n    (dreq_n),
        .seq_idle  (seq_idle),
        .cycle_end (cycle_end),
        .pending   (req_pending)
    );

    xfer_seq #(
        .WAIT_MIN (WAIT_MIN),
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pending   (req_pending),
        .chan_en   (chan_en),
        .bus_grant (bus_grant),
        .seq_idle  (seq_idle),
        .cycle_end (cycle_end),
        .busy      (cycle_busy),
        .dack      (dack)
    );

endmodule

// File: rtl/dreq_edge_channel_chk.sv
module dreq_edge_channel_chk #(
    parameter int WAIT_MIN = 3,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2
) (
    input logic clk,
    input logic rst,
    input logic dreq_n,
    input logic bus_grant,
    input logic req_pending,
    input logic dack,
    input logic cycle_busy,
    input logic xfer_done
);

    localparam int GW = $clog2(WAIT_MIN + 1) + 1;
    localparam int LW = $clog2(RD_CYC + WR_CYC + 1) + 1;
    localparam logic [GW-1:0] GAP_SAT = {GW{1'b1}};
    localparam logic [LW-1:0] LEN_SAT = {LW{1'b1}};

    logic [GW-1:0] gap_cnt;
    logic [LW-1:0] len_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            len_cnt <= '0;
        end else begin
            if (req_pending) begin
                gap_cnt <= '0;
            end else if (gap_cnt != GAP_SAT) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (!dack) begin
                len_cnt <= '0;
            end else if (len_cnt != LEN_SAT) begin
                len_cnt <= len_cnt + 1'b1;
            end
        end
    end

    assert_pending_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        req_pending |=> !req_pending);

    assert_pending_from_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(req_pending) |-> !$past(dreq_n));

    assert_wait_min_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cycle_busy) |-> (int'(gap_cnt) >= WAIT_MIN));

    assert_grant_before_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cycle_busy) |-> $past(bus_grant));

    assert_cycle_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(dack) |-> (int'(len_cnt) == RD_CYC + WR_CYC));

    assert_no_request_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        dack |-> !req_pending);

    assert_done_at_cycle_end_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (!dack && $past(dack)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

endmodule

bind dreq_edge_channel dreq_edge_channel_chk #(
    .WAIT_MIN (WAIT_MIN),
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dreq_n      (dreq_n),
    .bus_grant   (bus_grant),
    .req_pending (req_pending),
    .dack        (dack),
    .cycle_busy  (cycle_busy),
    .xfer_done   (xfer_done)
);

// File: tb/test_dreq_edge_channel.sv
module test_dreq_edge_channel;

    localparam int CW = 8;
    localparam int WM = 3;
    localparam int RD = 2;
    localparam int WR = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_wr = 1'b0;
    logic          en_wdata = 1'b0;
    logic [CW-1:0] xfer_count = '0;
    logic          dreq_n = 1'b1;
    logic          bus_grant = 1'b1;
    logic          req_pending;
    logic          dack;
    logic          cycle_busy;
    logic          xfer_done;

    always #4 clk = ~clk;

    dreq_edge_channel #(
        .CNT_W (CW), .WAIT_MIN (WM), .RD_CYC (RD), .WR_CYC (WR)
    ) i_dreq_edge_channel (
        .clk (clk), .rst (rst), .en_wr (en_wr), .en_wdata (en_wdata),
        .xfer_count (xfer_count), .dreq_n (dreq_n), .bus_grant (bus_grant),
        .req_pending (req_pending), .dack (dack), .cycle_busy (cycle_busy),
        .xfer_done (xfer_done)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        int lat;
        int len;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: measures pending-to-dack latency and dack length, pops expected
    bit pend_prev = 1'b0;
    bit dack_prev = 1'b0;
    bit waiting   = 1'b0;
    int lat_cnt   = 0;
    int rise_lat  = 0;
    int len_cnt   = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (waiting) lat_cnt++;
            if (req_pending && !pend_prev) begin
                waiting = 1'b1;
                lat_cnt = 0;
            end
            if (dack) len_cnt++;
            if (dack && !dack_prev) begin
                rise_lat = lat_cnt;
                waiting  = 1'b0;
            end
            if (dack && req_pending) begin
                check(1'b0, "R6 request held during cycle", 1, 0);
            end
            if (dack != cycle_busy) begin
                check(1'b0, "R5 dack differs from busy", int'(dack), int'(cycle_busy));
            end
            if (!dack && dack_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected transfer", len_cnt, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rise_lat == e.lat, "R4 request-to-cycle latency", rise_lat, e.lat);
                    check(len_cnt == e.len, "R5 cycle length", len_cnt, e.len);
                end
                len_cnt = 0;
            end
            pend_prev = req_pending;
            dack_prev = dack;
        end
    end

    task automatic write_en(input bit v, input int n);
        @(negedge clk);
        en_wr      = 1'b1;
        en_wdata   = v;
        xfer_count = CW'(n);
        @(negedge clk);
        en_wr      = 1'b0;
    endtask

    task automatic wait_dack_fall();
        do @(negedge clk); while (!dack);
        do @(negedge clk); while (dack);
    endtask

    // one serviced request; armed channel and dreq_n high on entry
    task automatic serve(input int gdly, input bit hold_low, input bit exp_done);
        exp_t e;
        e.lat = (gdly > 0) ? gdly + 1 : WM + 1;
        e.len = RD + WR;
        exp_q.push_back(e);
        if (gdly > 0) bus_grant = 1'b0;
        @(negedge clk);
        dreq_n = 1'b0;
        @(negedge clk);
        check(req_pending === 1'b1, "R3 low sample latches request", int'(req_pending), 1);
        if (!hold_low) dreq_n = 1'b1;
        @(negedge clk);
        check(req_pending === 1'b0, "R3 activation clears request", int'(req_pending), 0);
        if (gdly > 0) begin
            repeat (gdly - 1) @(negedge clk);
            bus_grant = 1'b1;
        end
        wait_dack_fall();
        check(xfer_done === exp_done, "R7 done at cycle end", int'(xfer_done), int'(exp_done));
        @(negedge clk);
        check(xfer_done === 1'b0, "R7 done lasts one cycle", int'(xfer_done), 0);
    endtask

    task automatic no_request(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req_pending === 1'b0, req, int'(req_pending), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        check(req_pending === 1'b0, "R1 reset pending", int'(req_pending), 0);
        check(dack === 1'b0, "R1 reset dack", int'(dack), 0);
        check(cycle_busy === 1'b0, "R1 reset busy", int'(cycle_busy), 0);
        check(xfer_done === 1'b0, "R1 reset done", int'(xfer_done), 0);
        rst = 1'b0;

        // R2: low request while disabled is ignored
        dreq_n = 1'b0;
        no_request(5, "R2 ignored while disabled");

        // R2: sampling starts the edge after the enabling write
        begin
            exp_t e;
            e.lat = WM + 1;
            e.len = RD + WR;
            exp_q.push_back(e);
        end
        write_en(1'b1, 3);
        check(req_pending === 1'b0, "R2 write edge does not sample", int'(req_pending), 0);
        @(negedge clk);
        check(req_pending === 1'b1, "R2 first sample after write", int'(req_pending), 1);
        wait_dack_fall();
        check(xfer_done === 1'b0, "R7 no done before count ends", int'(xfer_done), 0);

        // R6: request held low through cycle end keeps the channel disarmed
        no_request(6, "R6 held low does not re-arm");
        @(negedge clk);
        dreq_n = 1'b1;
        serve(0, 1'b0, 1'b0);

        // R4: grant withheld, last transfer of three
        serve(10, 1'b0, 1'b1);

        // R7: after the last transfer the pin is no longer sampled
        dreq_n = 1'b0;
        no_request(6, "R7 stopped after done");
        dreq_n = 1'b1;

        // R8: zero count leaves channel disabled
        write_en(1'b1, 0);
        @(negedge clk);
        dreq_n = 1'b0;
        @(negedge clk);
        dreq_n = 1'b1;
        check(req_pending === 1'b0, "R8 zero count ignored", int'(req_pending), 0);
        no_request(2, "R8 zero count ignored");

        // R8: disabling write drops arming
        write_en(1'b1, 4);
        write_en(1'b0, 0);
        @(negedge clk);
        dreq_n = 1'b0;
        @(negedge clk);
        dreq_n = 1'b1;
        check(req_pending === 1'b0, "R8 disabled channel ignores low", int'(req_pending), 0);
        no_request(2, "R8 disabled channel ignores low");

        // R7: single-transfer run ends with done
        write_en(1'b1, 1);
        serve(0, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 every expected transfer seen", exp_q.size(), 0);
        report();
        $finish;
    end

endmodule